// File: doc/BRIEF.md
# DMA Request/Grant Handshake Controller

This block serves single-word DMA transfers for an external device that asks for service with an active-low request line. Each request that the controller accepts becomes one access. The access takes one base cycle plus a programmed number of wait states. In the two strobe modes, an active-low grant is driven low for the length of the access. The external device uses that grant window either to latch write data or to drive read data. In the paced mode, the access runs on the read or write strobe alone and the grant stays high.

The request line is asynchronous to the controller clock. It passes through a two-flop synchronizer and is acted on at its high-to-low transition. The device can lengthen an access by keeping its request low past the programmed wait states. The access then ends only after the synchronized request is seen high again. After every completed access the controller does three things:
- It emits a one-cycle transfer-done pulse.
- It decrements a loadable word count.
- It can insert one idle cycle before it accepts the next request.

A strobe-mode access aimed at SDRAM in the external handshake mode is refused and reported.

The state machine has six states:
- `ST_IDLE`: waiting for a request edge.
- `ST_ACCESS`: base cycle and wait states.
- `ST_STRETCH`: the requester is prolonging the access.
- `ST_DONE`: transfer-done cycle.
- `ST_HOLD`: optional idle cycle.
- `ST_REFUSE`: error pulse for a refused request.

The transitions are:
- IDLE→ACCESS on an accepted edge.
- IDLE→REFUSE on an edge in external mode with the SDRAM target.
- ACCESS→ACCESS while wait states remain.
- ACCESS→STRETCH if the request is still low at the last wait cycle.
- ACCESS→DONE otherwise.
- STRETCH→DONE when the request is seen high.
- DONE→HOLD when the idle cycle is enabled.
- DONE→IDLE otherwise.
- HOLD→IDLE.
- REFUSE→IDLE.

Top module: `dma_hs_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the state to idle. After reset, `grant_n`, `rd_n` and `wr_n` are high, `xfer_done` and `mode_err` are low, and `words_left` is 0.
- R2: If `req_n` is first sampled low at rising edge N and the request is accepted, the access state is entered at edge N+2. From that edge the grant (strobe modes) or the strobe (paced mode) is low.
- R3: In the handshake mode (`mode` = 0) and in the external handshake mode (`mode` = 1) with `target_sdram` = 0, `grant_n` is low for max(1 + W, L) cycles. W is `wait_states` captured at acceptance, and L is the number of rising edges at which `req_n` was sampled low.
- R4: During an access, `wr_n` is low exactly while the access lasts when `dir_write` was 1 at acceptance, and `rd_n` is low when it was 0. The other strobe stays high. In the strobe modes, the strobe falls and rises on the same edges as `grant_n`.
- R5: In the paced mode (`mode` = 2 or 3), `grant_n` stays high for the whole transfer. The strobe is low for max(1 + W, L) cycles.
- R6: If the synchronized request is still low at the last wait cycle, the access is prolonged. It ends on the edge after the edge at which the synchronized request is first seen high.
- R7: On the cycle after each access, `xfer_done` is high for exactly one cycle. At the end of that cycle `words_left` decreases by one.
- R8: With `hold_en` = 1, one extra cycle with no access follows the done cycle. A request edge detected in that cycle is dropped.
- R9: In the external handshake mode with `target_sdram` = 1, an accepted request edge produces a one-cycle `mode_err` pulse at edge N+2. It causes no grant, no strobe and no change to `words_left`.
- R10: While `words_left` is 0, request edges are ignored in every mode. No access and no error result.
- R11: Only a high-to-low edge of the synchronized request detected in idle starts a transfer. Edges detected during an access, done, hold or refuse cycle are dropped, and a level held low does not start a second transfer.
- R12: `load_count` = 1 loads `count_val` into `words_left` at the next edge, taking priority over the done-cycle decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Asynchronous active-low transfer request |
| mode | input | 2 | 0 handshake, 1 external handshake, 2 or 3 paced |
| target_sdram | input | 1 | Target memory is SDRAM |
| dir_write | input | 1 | 1 = write transfer, 0 = read transfer |
| wait_states | input | WS_W | Wait states added to the base cycle |
| hold_en | input | 1 | Insert one idle cycle after each transfer |
| load_count | input | 1 | Load the word count |
| count_val | input | CNT_W | Value loaded into the word count |
| grant_n | output | 1 | Active-low grant strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| xfer_done | output | 1 | One-cycle pulse per completed transfer |
| mode_err | output | 1 | One-cycle pulse for a refused request |
| words_left | output | CNT_W | Remaining word count |

## Verification
The main cost of a request is its latency, so each check is sampled at the cycle in which its result is due:
- Grant and strobe go low after the second edge following the edge that first samples `req_n` low.
- `mode_err` appears at that same point.
- `xfer_done` follows one cycle after the grant rises.
- `words_left` moves at the edge that closes the done cycle.

The bench models these delays with a sample queue and a phase counter that advance on every rising edge. It drives inputs and compares all outputs on falling edges, so each comparison falls half a cycle after the edge that produced it. Directed windows also count grant-low, strobe-low, done and error cycles over a fixed span, giving totals that do not depend on the exact alignment.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_STRETCH,
        ST_DONE,
        ST_HOLD,
        ST_REFUSE
    } dmah_state_e;

    localparam logic [1:0] MODE_HS  = 2'd0;
    localparam logic [1:0] MODE_EXT = 2'd1;

endpackage

// File: rtl/dmah_sync.sv
module dmah_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_n_async,
    output logic req_low,
    output logic req_fall
);

    logic [STAGES-1:0] pipe;
    logic              prev_low;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= 1'b1;
        else     pipe[0] <= req_n_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= 1'b1;
            else     pipe[g] <= pipe[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_low <= 1'b0;
        else     prev_low <= req_low;
    end

    assign req_low  = ~pipe[STAGES-1];
    assign req_fall = req_low & ~prev_low;

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        req_fall |=> !req_fall);  // R11

endmodule

// File: rtl/dmah_wcount.sv
module dmah_wcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero
);

    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (load)                count <= load_val;
        else if (dec && count != '0)  count <= count - CNT_W'(1);
    end

    assign is_zero = (count == '0);

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && count != '0) |=> count == $past(count) - CNT_W'(1));  // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));  // R12

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
    import dmah_pkg::*;
#(
    parameter int WS_W  = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_n,
    input  logic [1:0]       mode,
    input  logic             target_sdram,
    input  logic             dir_write,
    input  logic [WS_W-1:0]  wait_states,
    input  logic             hold_en,
    input  logic             load_count,
    input  logic [CNT_W-1:0] count_val,
    output logic             grant_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic             xfer_done,
    output logic             mode_err,
    output logic [CNT_W-1:0] words_left
);

    localparam int SYNC_STAGES = 2;

    dmah_state_e     state_q, state_d;
    logic [WS_W-1:0] wait_q, wait_d;
    logic            dir_q, dir_d;
    logic            paced_q, paced_d;
    logic            req_low, req_fall, cnt_zero, in_access, refuse;

    dmah_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .req_n_async(req_n),
        .req_low    (req_low),
        .req_fall   (req_fall)
    );

    dmah_wcount #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .load    (load_count),
        .load_val(count_val),
        .dec     (xfer_done),
        .count   (words_left),
        .is_zero (cnt_zero)
    );

    assign refuse = (mode == MODE_EXT) && target_sdram;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            dir_q   <= 1'b0;
            paced_q <= 1'b0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            dir_q   <= dir_d;
            paced_q <= paced_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        dir_d   = dir_q;
        paced_d = paced_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fall && !cnt_zero) begin
                    if (refuse) begin
                        state_d = ST_REFUSE;
                    end else begin
                        state_d = ST_ACCESS;
                        wait_d  = wait_states;
                        dir_d   = dir_write;
                        paced_d = mode[1];
                    end
                end
            end
            ST_ACCESS: begin
                if (wait_q != '0)  wait_d  = wait_q - WS_W'(1);
                else if (req_low)  state_d = ST_STRETCH;
                else               state_d = ST_DONE;
            end
            ST_STRETCH: begin
                if (!req_low) state_d = ST_DONE;
            end
            ST_DONE:   state_d = hold_en ? ST_HOLD : ST_IDLE;
            ST_HOLD:   state_d = ST_IDLE;
            ST_REFUSE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_access = (state_q == ST_ACCESS) || (state_q == ST_STRETCH);
        grant_n   = !(in_access && !paced_q);
        wr_n      = !(in_access && dir_q);
        rd_n      = !(in_access && !dir_q);
        xfer_done = (state_q == ST_DONE);
        mode_err  = (state_q == ST_REFUSE);
    end

    AST_GRANT_FRAMED: assert property (@(posedge clk) disable iff (rst)
        !grant_n |-> (rd_n != wr_n));  // R4
    AST_PACED_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (paced_q && state_q != ST_IDLE) |-> grant_n);  // R5
    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STRETCH && req_low) |=> (state_q == ST_STRETCH));  // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);  // R7
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> (state_q == ST_IDLE));  // R8
    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (grant_n && rd_n && wr_n && !xfer_done));  // R9
    AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cnt_zero) |=> (state_q == ST_IDLE));  // R10
    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DONE) |=> (state_q != ST_ACCESS));  // R11

endmodule

// File: tb/test_dma_hs_ctrl.sv
module test_dma_hs_ctrl;

    localparam int WS_W  = 4;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_n = 1'b1;
    logic [1:0]       mode = 2'd0;
    logic             target_sdram = 1'b0;
    logic             dir_write = 1'b0;
    logic [WS_W-1:0]  wait_states = '0;
    logic             hold_en = 1'b0;
    logic             load_count = 1'b0;
    logic [CNT_W-1:0] count_val = '0;
    logic             grant_n, rd_n, wr_n, xfer_done, mode_err;
    logic [CNT_W-1:0] words_left;

    dma_hs_ctrl #(.WS_W(WS_W), .CNT_W(CNT_W)) i_dma_hs_ctrl (
        .clk(clk), .rst(rst), .req_n(req_n), .mode(mode),
        .target_sdram(target_sdram), .dir_write(dir_write),
        .wait_states(wait_states), .hold_en(hold_en),
        .load_count(load_count), .count_val(count_val),
        .grant_n(grant_n), .rd_n(rd_n), .wr_n(wr_n),
        .xfer_done(xfer_done), .mode_err(mode_err), .words_left(words_left)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model: phase 0 idle, 1 access, 2 stretch, 3 done, 4 hold, 5 refuse
    int phase = 0, m_wait = 0, m_cnt = 0;
    bit m_dir = 0, m_paced = 0, m_low = 0, m_fall = 0;
    bit samples[$];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            phase = 0; m_wait = 0; m_cnt = 0; m_dir = 0; m_paced = 0;
            m_low = 0; m_fall = 0; samples.delete();
        end else begin
            int  nxt;
            bit  new_low;
            nxt = phase;
            case (phase)
                0: if (m_fall && m_cnt != 0) begin
                       if (mode == 2'd1 && target_sdram) nxt = 5;
                       else begin
                           nxt = 1; m_wait = int'(wait_states);
                           m_dir = dir_write; m_paced = (mode >= 2'd2);
                       end
                   end
                1: if (m_wait > 0) m_wait--; else nxt = m_low ? 2 : 3;
                2: if (!m_low) nxt = 3;
                3: nxt = hold_en ? 4 : 0;
                default: nxt = 0;
            endcase
            if (load_count) m_cnt = int'(count_val);
            else if (phase == 3 && m_cnt > 0) m_cnt--;
            phase = nxt;
            samples.push_back(req_n);
            if (samples.size() > 2) void'(samples.pop_front());
            new_low = (samples.size() == 2) ? !samples[0] : 1'b0;
            m_fall = new_low && !m_low;
            m_low  = new_low;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            bit acc;
            acc = (phase == 1 || phase == 2);
            chk(cur_tag, "grant_n", int'(grant_n), int'(!(acc && !m_paced)));
            chk(cur_tag, "wr_n", int'(wr_n), int'(!(acc && m_dir)));
            chk(cur_tag, "rd_n", int'(rd_n), int'(!(acc && !m_dir)));
            chk(cur_tag, "xfer_done", int'(xfer_done), int'(phase == 3));
            chk(cur_tag, "mode_err", int'(mode_err), int'(phase == 5));
            chk(cur_tag, "words_left", int'(words_left), m_cnt);
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Drive req_n per low_mask bit i at step i; count outputs over the window
    task automatic xfer(input logic [31:0] low_mask, input logic [31:0] load_mask,
                        output int g_lo, output int s_lo, output int dn, output int er);
        g_lo = 0; s_lo = 0; dn = 0; er = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            req_n = !low_mask[i];
            load_count = load_mask[i];
            if (!grant_n) g_lo++;
            if (!rd_n || !wr_n) s_lo++;
            if (xfer_done) dn++;
            if (mode_err) er++;
        end
        req_n = 1'b1;
        load_count = 1'b0;
    endtask

    task automatic load(input int v);
        @(negedge clk);
        count_val = CNT_W'(v);
        load_count = 1'b1;
        @(negedge clk);
        load_count = 1'b0;
    endtask

    initial begin
        int g, s, d, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_tag = "R1";
        chk("R1", "reset grant_n", int'(grant_n), 1);
        chk("R1", "reset strobes", int'(rd_n & wr_n), 1);
        chk("R1", "reset pulses", int'(xfer_done | mode_err), 0);
        chk("R1", "reset words_left", int'(words_left), 0);

        cur_tag = "R12"; load(20);
        chk("R12", "loaded count", int'(words_left), 20);

        cur_tag = "R2 R3 R4 R7"; mode = 2'd0; dir_write = 1'b0; wait_states = 0;
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R3", "hs read grant cycles", g, 1);
        chk("R4", "hs read strobe cycles", s, 1);
        chk("R7", "done pulses", d, 1);
        chk("R7", "count after one", int'(words_left), 19);

        cur_tag = "R3 R4"; dir_write = 1'b1; wait_states = 3;
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R3", "hs write W=3 grant cycles", g, 4);
        chk("R4", "hs write strobe cycles", s, 4);

        cur_tag = "R6 R11"; wait_states = 1;
        xfer(32'hFF, 32'h0, g, s, d, e);
        chk("R6", "stretched grant cycles", g, 8);
        chk("R11", "held level one transfer", d, 1);

        cur_tag = "R5"; mode = 2'd2; dir_write = 1'b0; wait_states = 2;
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R5", "paced grant cycles", g, 0);
        chk("R5", "paced strobe cycles", s, 3);
        mode = 2'd3;
        xfer(32'h7, 32'h0, g, s, d, e);
        chk("R5", "paced mode3 stretched strobe", s, 3);

        cur_tag = "R9"; mode = 2'd1; target_sdram = 1'b1; wait_states = 0;
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R9", "refused grant cycles", g, 0);
        chk("R9", "refused strobe cycles", s, 0);
        chk("R9", "error pulses", e, 1);
        chk("R9", "count unchanged", int'(words_left), 15);
        cur_tag = "R3"; target_sdram = 1'b0;
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R3", "ext non-sdram grant cycles", g, 1);

        cur_tag = "R8"; mode = 2'd0; hold_en = 1'b1;
        xfer(32'h9, 32'h0, g, s, d, e);
        chk("R8", "edge in hold dropped", d, 1);
        hold_en = 1'b0;
        xfer(32'h9, 32'h0, g, s, d, e);
        chk("R8", "same edges without hold", d, 2);

        cur_tag = "R11"; wait_states = 5;
        xfer(32'h9, 32'h0, g, s, d, e);
        chk("R11", "edge during access dropped", d, 1);
        chk("R11", "grant cycles", g, 6);

        cur_tag = "R12"; wait_states = 0; count_val = 8'd7;
        xfer(32'h1, 32'h10, g, s, d, e);
        chk("R12", "load beats decrement", int'(words_left), 7);

        cur_tag = "R10"; load(1);
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R10", "last word runs", d, 1);
        chk("R10", "count reached zero", int'(words_left), 0);
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R10", "grant at zero", g, 0);
        chk("R10", "done at zero", d, 0);
        mode = 2'd1; target_sdram = 1'b1;
        xfer(32'h1, 32'h0, g, s, d, e);
        chk("R10", "no error at zero", e, 0);

        cur_tag = "R1"; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "count after reset", int'(words_left), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule